// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt inputs and presents a single request line to a processor. Each input is recorded in a request register, which holds the edge or the level depending on the trigger mode. The block ignores inputs that are disabled in a mask register. It then chooses the most urgent remaining input by fixed priority. When the processor acknowledges, the block moves that input into an in-service register. The vector output carries a programmed base in its upper five bits and the level number in its lower three.

Software reaches the block through a byte-wide register port with a one-bit address. A write to the low address with data bit 4 set restarts setup. The block then takes the base vector, an optional cascade byte and an optional options byte. After setup, the high address writes the mask. The low address takes end-of-interrupt commands, read-select commands and a poll command. Bit 3 of the written byte tells these command kinds apart.

Top module: `pic8_ctrl`

## Requirements
- R1: A low-address write with data bit 4 set clears the mask, in-service and request registers, the read select (back to requests), special mask mode and any pending poll. It then holds `int_req` low until setup completes. It latches bit 3 (1 = level, 0 = edge), bit 1 (1 = no cascade byte) and bit 0 (1 = options byte follows), and it clears automatic EOI.
- R2: After that restart, high-address writes are taken in order as the base byte (bits 7:3 kept), then the cascade byte only when bit 1 was clear, then the options byte only when bit 0 was set (bit 1 = automatic EOI). Later high-address writes load the mask, and a high-address read returns the mask.
- R3: In edge mode a request bit sets on a 0-to-1 input transition and stays set until that level is acknowledged. An input held high does not request again after acknowledge.
- R4: In level mode the request register follows the inputs each cycle, so a dropped input withdraws its request, and a held input requests again after automatic EOI.
- R5: A mask bit of 1 keeps that input from raising `int_req`, but the request register still records it.
- R6: Input 0 has the highest priority. `vec_out` is {base, level of the highest unmasked pending input}, or {base, 7} when none is pending. `int_req` is high only when no in-service bit is at that level or a higher-priority one.
- R7: Acknowledging while `int_req` is high clears the chosen request bit (edge mode) and sets its in-service bit. In automatic EOI mode no in-service bit is set.
- R8: Low-address command 0x20 (bits 4,3 = 0, bit 5 = 1, bit 6 = 0) clears the highest-priority in-service bit.
- R9: Command 0x60|L clears in-service bit L. A command with bits 4, 3 and 5 all clear changes nothing.
- R10: Low-address command with bit 3 = 1 and bit 1 = 1 sets the low-address read to in-service (bit 0 = 1) or request (bit 0 = 0). With bit 1 clear, the selection is kept.
- R11: Command with bit 3 and bit 2 set arms a poll. The next low-address read returns {pending, 0000, level} (all zero when none) and acknowledges that level.
- R12: Command bit 6 = 1 loads special mask mode from bit 5 (0x68 on, 0x48 off). In that mode, in-service levels stop blocking other unmasked requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address (0 low, 1 high) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rd_en` is high |
| irq_line | input | 8 | Interrupt inputs, bit 0 most urgent |
| ack | input | 1 | One-cycle acknowledge from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the currently selected level |

## Verification
A stray in-service bit blocks every lower level. It shows at `int_req` on the first cycle a blocked input becomes pending, and it can be read back right away through the in-service select. A sequencer that takes the wrong number of setup bytes shows up one write later, when a mask byte reads back wrong or a setup byte reads back as a mask. The bench model tracks every register behaviourally and compares `int_req`, `vec_out` and read data every cycle, so a divergence is reported in the first cycle it reaches a port.

// File: rtl/pic8_pkg.sv
// Shared constants and types for the priority interrupt controller.
// Assumes a byte-wide register port and a power-of-two input count.
package pic8_pkg;
    localparam int DW  = 8;
    localparam int NIN = 8;
    localparam int LW  = $clog2(NIN);
    localparam int BW  = DW - LW;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE,
        ST_CASC,
        ST_OPTS,
        ST_READY
    } seq_e;

    typedef struct packed {
        logic          level_trig;
        logic          aeoi;
        logic [BW-1:0] base;
    } cfg_t;
endpackage

// File: rtl/pic8_init_seq.sv
// Setup sequencer: walks the restart/base/cascade/options byte chain and
// steers later writes to the mask or to command decode.
// Assumes wdata bits are split by the caller: hi_bits = [7:3], lo_bits = [1:0].
module pic8_init_seq
    import pic8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [BW-1:0] hi_bits,
    input  logic [1:0]    lo_bits,
    output cfg_t          cfg,
    output logic          ready,
    output logic          restart,
    output logic          op_wr,
    output logic          mask_wr
);
    seq_e st_q;
    logic single_q;
    logic want_opts_q;

    // Decode strobes from the address and the opcode bits in the data.
    always_comb begin
        restart = wr_en && !addr && hi_bits[1];
        ready   = (st_q == ST_READY);
        op_wr   = wr_en && !addr && !hi_bits[1] && ready;
        mask_wr = wr_en && addr && ready;
    end

    // Step through the setup chain and latch configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            single_q    <= 1'b0;
            want_opts_q <= 1'b0;
            cfg         <= '0;
        end else if (restart) begin
            st_q           <= ST_BASE;
            cfg.level_trig <= hi_bits[0];
            single_q       <= lo_bits[1];
            want_opts_q    <= lo_bits[0];
            cfg.aeoi       <= 1'b0;
        end else if (wr_en && addr) begin
            unique case (st_q)
                ST_BASE: begin
                    cfg.base <= hi_bits;
                    if (!single_q)        st_q <= ST_CASC;
                    else if (want_opts_q) st_q <= ST_OPTS;
                    else                  st_q <= ST_READY;
                end
                ST_CASC: st_q <= want_opts_q ? ST_OPTS : ST_READY;
                ST_OPTS: begin
                    cfg.aeoi <= lo_bits[1];
                    st_q     <= ST_READY;
                end
                default: ;
            endcase
        end
    end

    assert_restart_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !ready);
endmodule

// File: rtl/pic8_req_capture.sv
// Request register: records rising edges or follows levels per input.
// Assumes inputs are already synchronous to clk.
module pic8_req_capture #(
    parameter int NIN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_all,
    input  logic           level_mode,
    input  logic [NIN-1:0] irq_line,
    input  logic [NIN-1:0] ack_clr,
    output logic [NIN-1:0] irr
);
    logic [NIN-1:0] prev_q;

    // Remember last input sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_line;
    end

    // Update pending requests per trigger mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) irr <= '0;
        else if (level_mode)   irr <= irq_line;
        else                   irr <= (irr | (irq_line & ~prev_q)) & ~ack_clr;
    end

    assert_edge_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !clr_all && irq_line == '0) |=> ((irr & ~$past(irr)) == '0));
endmodule

// File: rtl/pic8_prio.sv
// Fixed-priority resolver: lowest index wins, in-service levels block
// equal and lower priority unless special mask mode is on.
// Purely combinational.
module pic8_prio #(
    parameter int NIN = 8,
    parameter int LW  = $clog2(NIN)
) (
    input  logic [NIN-1:0] irr,
    input  logic [NIN-1:0] mask,
    input  logic [NIN-1:0] isr,
    input  logic           smm,
    output logic           req,
    output logic [LW-1:0]  winner,
    output logic [LW-1:0]  isr_top,
    output logic           isr_any
);
    logic [NIN-1:0] cand;

    function automatic logic [LW-1:0] first_set(input logic [NIN-1:0] v);
        logic [LW-1:0] r;
        r = LW'(NIN - 1);
        for (int i = NIN - 1; i >= 0; i--) begin
            if (v[i]) r = LW'(i);
        end
        return r;
    endfunction

    // Pick the most urgent eligible request and the most urgent in-service level.
    always_comb begin
        cand    = irr & ~mask & (smm ? ~isr : {NIN{1'b1}});
        winner  = first_set(cand);
        isr_top = first_set(isr);
        isr_any = |isr;
        req     = (|cand) && (smm || !isr_any || (winner < isr_top));
    end
endmodule

// File: rtl/pic8_ctrl.sv
// Top of the eight-input priority interrupt controller: holds mask,
// in-service, read select, special mask and poll state; decodes commands,
// acknowledges and reads. Assumes ack is a one-cycle pulse.
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [NIN-1:0] irq_line,
    input  logic          ack,
    output logic          int_req,
    output logic [DW-1:0] vec_out
);
    cfg_t           cfg;
    logic           ready, restart, op_wr, mask_wr;
    logic [NIN-1:0] irr, isr_q, mask_q, ack_vec, eoi_vec;
    logic           rd_isr_q, smm_q, poll_q;
    logic           req, isr_any, poll_take, ack_do, is_eoi_cmd, is_sel_cmd;
    logic [LW-1:0]  winner, isr_top, poll_lvl;

    pic8_init_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .hi_bits (wdata[DW-1:LW]),
        .lo_bits (wdata[1:0]),
        .cfg     (cfg),
        .ready   (ready),
        .restart (restart),
        .op_wr   (op_wr),
        .mask_wr (mask_wr)
    );

    pic8_req_capture #(.NIN(NIN)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all    (restart),
        .level_mode (cfg.level_trig),
        .irq_line   (irq_line),
        .ack_clr    (ack_vec),
        .irr        (irr)
    );

    pic8_prio #(.NIN(NIN), .LW(LW)) u_prio (
        .irr     (irr),
        .mask    (mask_q),
        .isr     (isr_q),
        .smm     (smm_q),
        .req     (req),
        .winner  (winner),
        .isr_top (isr_top),
        .isr_any (isr_any)
    );

    // Acknowledge, command decode and EOI target selection.
    always_comb begin
        int_req    = ready && req;
        poll_take  = rd_en && !addr && poll_q;
        ack_do     = int_req && (ack || poll_take);
        is_eoi_cmd = op_wr && !wdata[3] && wdata[5];
        is_sel_cmd = op_wr && wdata[3];
        ack_vec    = '0;
        if (ack_do) ack_vec[winner] = 1'b1;
        eoi_vec = '0;
        if (is_eoi_cmd) begin
            if (wdata[6])     eoi_vec[wdata[LW-1:0]] = 1'b1;
            else if (isr_any) eoi_vec[isr_top] = 1'b1;
        end
        poll_lvl = int_req ? winner : '0;
        vec_out  = {cfg.base, winner};
    end

    // In-service register: EOI clears, acknowledge sets unless automatic EOI.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) isr_q <= '0;
        else isr_q <= (isr_q & ~eoi_vec) | (cfg.aeoi ? '0 : ack_vec);
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) mask_q <= '0;
        else if (mask_wr)      mask_q <= wdata;
    end

    // Read select, special mask mode and one-shot poll.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            rd_isr_q <= 1'b0;
            smm_q    <= 1'b0;
            poll_q   <= 1'b0;
        end else if (is_sel_cmd) begin
            if (wdata[1]) rd_isr_q <= wdata[0];
            if (wdata[6]) smm_q    <= wdata[5];
            poll_q <= wdata[2];
        end else if (poll_take) begin
            poll_q <= 1'b0;
        end
    end

    // Read data multiplexer.
    always_comb begin
        if (!rd_en)        rdata = '0;
        else if (addr)     rdata = mask_q;
        else if (poll_q)   rdata = {int_req, {(DW-1-LW){1'b0}}, poll_lvl};
        else if (rd_isr_q) rdata = isr_q;
        else               rdata = irr;
    end

    assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> !mask_q[vec_out[LW-1:0]]);
    assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_do && !cfg.aeoi && !restart) |=> isr_q[$past(winner)]);
    assert_aeoi_no_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && cfg.aeoi && !restart) |=> ((isr_q & ~$past(isr_q)) == '0));
    assert_ns_eoi_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_eoi_cmd && !wdata[6] && isr_any && !ack_do) |=>
        ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: tb/pic8_ctrl_tb_top.sv
module pic8_ctrl_tb_top;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = 8'h00, irq_line = 8'h00;
    logic [7:0] rdata, vec_out;
    logic int_req;
    int errs = 0, checks = 0;

    pic8_ctrl dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_line(irq_line),
        .ack(ack), .int_req(int_req), .vec_out(vec_out));

    // ---------------- behavioural reference model ----------------
    int m_st;
    bit m_lt, m_sg, m_n4, m_ae, m_risr, m_smm, m_poll;
    bit [4:0] m_base;
    bit [7:0] m_irr, m_prev, m_isr, m_mask;

    function automatic int lowest(bit [7:0] v);
        int r = -1;
        for (int i = 7; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    function automatic bit [7:0] m_cand();
        return m_irr & ~m_mask & (m_smm ? ~m_isr : 8'hFF);
    endfunction

    function automatic int m_win();
        return (m_cand() == 0) ? 7 : lowest(m_cand());
    endfunction

    function automatic bit m_int();
        if (m_st != 4 || m_cand() == 0) return 1'b0;
        if (m_smm || m_isr == 0) return 1'b1;
        return m_win() < lowest(m_isr);
    endfunction

    function automatic bit [7:0] m_rd();
        bit [7:0] lv;
        if (addr) return m_mask;
        if (m_poll) begin
            lv = m_int() ? 8'(m_win()) : 8'h00;
            return {m_int(), 4'b0000, lv[2:0]};
        end
        return m_risr ? m_isr : m_irr;
    endfunction

    bit icw1, op, mw, intr, take;
    int w;
    bit [7:0] nirr, nisr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_lt = 0; m_sg = 0; m_n4 = 0; m_ae = 0; m_base = 0;
            m_irr = 0; m_prev = 0; m_isr = 0; m_mask = 0;
            m_risr = 0; m_smm = 0; m_poll = 0;
        end else begin
            icw1 = wr_en && !addr && wdata[4];
            op   = wr_en && !addr && !wdata[4] && m_st == 4;
            mw   = wr_en && addr && m_st == 4;
            intr = m_int();
            w    = m_win();
            take = intr && (ack || (rd_en && !addr && m_poll));
            if (icw1) nirr = 0;
            else if (m_lt) nirr = irq_line;
            else begin
                nirr = m_irr | (irq_line & ~m_prev);
                if (take) nirr[w] = 1'b0;
            end
            m_prev = irq_line;
            nisr = m_isr;
            if (op && !wdata[3] && wdata[5]) begin
                if (wdata[6]) nisr[wdata[2:0]] = 1'b0;
                else if (m_isr != 0) nisr[lowest(m_isr)] = 1'b0;
            end
            if (take && !m_ae) nisr[w] = 1'b1;
            if (icw1) begin
                nisr = 0; m_mask = 0; m_risr = 0; m_smm = 0; m_poll = 0;
            end else begin
                if (mw) m_mask = wdata;
                if (op && wdata[3]) begin
                    if (wdata[1]) m_risr = wdata[0];
                    if (wdata[6]) m_smm = wdata[5];
                    m_poll = wdata[2];
                end else if (rd_en && !addr && m_poll) m_poll = 0;
            end
            m_irr = nirr;
            m_isr = nisr;
            if (icw1) begin
                m_st = 1; m_lt = wdata[3]; m_sg = wdata[1]; m_n4 = wdata[0]; m_ae = 0;
            end else if (wr_en && addr) begin
                case (m_st)
                    1: begin m_base = wdata[7:3]; m_st = !m_sg ? 2 : (m_n4 ? 3 : 4); end
                    2: m_st = m_n4 ? 3 : 4;
                    3: begin m_ae = wdata[1]; m_st = 4; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk("R6 int_req vs model", {7'b0, int_req}, {7'b0, m_int()});
            chk("R6 vec_out vs model", vec_out, {m_base, 3'(m_win())});
            if (rd_en) chk("R10 rdata vs model", rdata, m_rd());
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0; addr = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk); irq_line = v;
        @(negedge clk);
    endtask

    task automatic chk_out(input string req, input logic ei, input logic [7:0] ev);
        chk({req, " int_req"}, {7'b0, int_req}, {7'b0, ei});
        if (ei) chk({req, " vec_out"}, vec_out, ev);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset int_req", {7'b0, int_req}, 8'h00);
        rd(1'b1, v); chk("R1 reset mask", v, 8'h00);

        // Edge mode, cascaded, options byte follows.
        wr(1'b0, 8'h11);
        chk("R1 int_req held during setup", {7'b0, int_req}, 8'h00);
        wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        wr(1'b1, 8'hF0);
        rd(1'b1, v); chk("R2 mask after full chain", v, 8'hF0);

        set_irq(8'h20); chk_out("R5 masked input", 1'b0, 8'h00);
        set_irq(8'h24); chk_out("R3 edge capture", 1'b1, 8'h42);
        set_irq(8'h25); chk_out("R6 input0 wins", 1'b1, 8'h40);
        wr(1'b0, 8'h0A); rd(1'b0, v); chk("R5 masked still recorded R10", v, 8'h25);

        pulse_ack(); chk_out("R7 ack blocks lower", 1'b0, 8'h00);
        wr(1'b0, 8'h0B); rd(1'b0, v); chk("R7 in-service set R10", v, 8'h01);
        wr(1'b0, 8'h08); rd(1'b0, v); chk("R10 select kept", v, 8'h01);
        wr(1'b0, 8'h00); rd(1'b0, v); chk("R9 no-op command", v, 8'h01);
        wr(1'b0, 8'h20); chk_out("R8 nonspecific EOI", 1'b1, 8'h42);
        rd(1'b0, v); chk("R8 isr cleared", v, 8'h00);

        pulse_ack(); chk_out("R7 second ack", 1'b0, 8'h00);
        repeat (2) @(negedge clk); chk_out("R3 held line no repeat", 1'b0, 8'h00);
        wr(1'b0, 8'h62); rd(1'b0, v); chk("R9 specific EOI", v, 8'h00);
        chk_out("R3 no new edge", 1'b0, 8'h00);

        set_irq(8'h00); set_irq(8'h02); chk_out("R6 level1", 1'b1, 8'h41);
        pulse_ack();
        set_irq(8'h0A); chk_out("R6 blocked by isr", 1'b0, 8'h00);
        wr(1'b0, 8'h68); chk_out("R12 special mask on", 1'b1, 8'h43);
        wr(1'b0, 8'h48); chk_out("R12 special mask off", 1'b0, 8'h00);
        wr(1'b0, 8'h61); chk_out("R9 specific EOI unblocks", 1'b1, 8'h43);

        wr(1'b0, 8'h0C); rd(1'b0, v); chk("R11 poll byte", v, 8'h83);
        wr(1'b0, 8'h0B); rd(1'b0, v); chk("R11 poll acknowledged", v, 8'h08);
        wr(1'b0, 8'h20);
        wr(1'b0, 8'h0C); rd(1'b0, v); chk("R11 poll empty", v, 8'h00);

        // Level mode, single, options byte with automatic EOI.
        wr(1'b0, 8'h1B);
        chk("R1 restart int_req", {7'b0, int_req}, 8'h00);
        rd(1'b1, v); chk("R1 restart mask", v, 8'h00);
        rd(1'b0, v); chk("R1 select back to requests R4", v, 8'h0A);
        wr(1'b1, 8'h80); wr(1'b1, 8'h03); wr(1'b1, 8'h11);
        rd(1'b1, v); chk("R2 cascade byte skipped", v, 8'h11);
        chk_out("R4 level request", 1'b1, 8'h81);
        set_irq(8'h08); chk_out("R4 level withdrawn", 1'b1, 8'h83);
        set_irq(8'h00); chk_out("R4 all low", 1'b0, 8'h00);
        chk("R6 idle vector", vec_out, 8'h87);
        set_irq(8'h04); pulse_ack(); chk_out("R4 re-request after auto EOI", 1'b1, 8'h82);
        wr(1'b0, 8'h0B); rd(1'b0, v); chk("R7 auto EOI keeps isr empty", v, 8'h00);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule